// File: doc/BRIEF.md
# Segmented Time-Slot Bus Arbiter

This block decides, cycle by cycle, which of several processors may drive a shared bus. It does not look at request order or priority. A free-running time counter walks through a static schedule that is programmed beforehand into a small table. The schedule is split into segments. Each segment starts at a fixed time and has a list of owners. The owners take the bus in list order, and that round repeats until the next segment begins. When the owner of a slot is not requesting, the slot stays idle and no other processor gets the bus.

One of three table interpretations is chosen at build time with the `MODE` parameter:
- In per-owner mode, every owner in a segment has its own slot length.
- In uniform mode, a single slot length is stored per segment and every owner in that segment uses it.
- In flat mode, each segment is one entry that gives the bus to its first listed owner from its start time until the next entry's start time.

The table is loaded through a write port, and only while the arbiter is disabled. Enabling the arbiter starts the schedule at time 0.

Top module: `tdma_seg_arbiter`

## Requirements
- R1: At most one bit of `gnt` is set in any cycle.
- R2: While enabled, `owner` reports the processor that owns the current slot, and a set `gnt` bit is always the bit at that owner's index.
- R3: `gnt` and `owner` change only on a slot boundary. Both are registered, and the values for a slot are valid in that slot's first cycle.
- R4: While `en` is low, `gnt` is zero and `owner` is 0. The first cycle after the clock edge that samples `en` high is time 0, which is the first slot of segment 0.
- R5: A write presented while `en` is high leaves the schedule unchanged.
- R6: In per-owner mode, the owners of a segment are served in index order 0, 1, … up to the segment's owner count minus one. Each owner gets its own programmed slot length in cycles, and the round repeats.
- R7: In uniform mode, every owner of a segment gets the segment's single slot length, and the owners are served in index order.
- R8: In flat mode, the owner at index 0 of each segment holds the slot from that segment's start time until the next segment's start time or the end of the period.
- R9: When the time counter reaches the start time of the next active segment, that segment begins with its owner at index 0, even if a slot of the previous segment is still running.
- R10: When the time reaches the period length minus one, the next cycle is time 0 of segment 0, owner index 0.
- R11: If the slot owner's request is low in the cycle before the slot starts, `gnt` stays zero for the whole slot.
- R12: The grant decision for a slot uses only the request in the cycle before the slot starts. A request that rises inside a slot is first honoured in that owner's next slot.
- R13: Write field codes on `cfg_field`:
  - 0: segment start time
  - 1: owner count of the segment
  - 2: uniform slot length
  - 3: owner processor at (`cfg_seg`, `cfg_idx`)
  - 4: owner slot length at (`cfg_seg`, `cfg_idx`)
  - 5: number of active segments
  - 6: period length in cycles

  A write made while disabled takes effect from the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the schedule; low holds the arbiter idle and opens the table for writes |
| req | input | NPROC | One request line per processor |
| cfg_we | input | 1 | Table write strobe |
| cfg_field | input | 3 | Field code of the write (see R13) |
| cfg_seg | input | $clog2(NSEG) | Segment addressed by the write |
| cfg_idx | input | $clog2(NOWN) | Owner position addressed by the write |
| cfg_data | input | TW | Write value |
| gnt | output | NPROC | Registered one-hot bus grant |
| owner | output | $clog2(NPROC) | Owner of the current slot |

## Verification
A single schedule is programmed into three instances, one per mode, and each instance is compared every cycle against a model that derives the owner from the time of the period.

With all processors requesting, a wrong slot length, a wrong round order, a late segment switch or a missed period wrap each shows up as a mismatch. Driving a single requester separates idle slots from slots that were wrongly reassigned. A request that rises in the middle of an owner's slot shows whether the grant is decided at the slot boundary. A table write made while running, followed by a changed schedule loaded while disabled, tells a locked table apart from one that is live.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
   localparam int MODE_FLAT = 0;
   localparam int MODE_UNI  = 1;
   localparam int MODE_PER  = 2;

   typedef enum logic [2:0] {
      FLD_SEG_START = 3'd0,
      FLD_SEG_CNT   = 3'd1,
      FLD_SEG_LEN   = 3'd2,
      FLD_OWN_ID    = 3'd3,
      FLD_OWN_LEN   = 3'd4,
      FLD_NSEG      = 3'd5,
      FLD_PERIOD    = 3'd6
   } cfg_field_e;
endpackage

// File: rtl/tdma_sched_table.sv
module tdma_sched_table
   import tdma_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int NSEG  = 4,
   parameter int NOWN  = 4,
   parameter int TW    = 16,
   parameter int LW    = 8,
   localparam int PW   = $clog2(NPROC),
   localparam int SW   = $clog2(NSEG),
   localparam int OW   = $clog2(NOWN),
   localparam int CSW  = $clog2(NSEG + 1),
   localparam int OCW  = $clog2(NOWN + 1)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_ok,
   input  logic                               cfg_we,
   input  logic [2:0]                         cfg_field,
   input  logic [SW-1:0]                      cfg_seg,
   input  logic [OW-1:0]                      cfg_idx,
   input  logic [TW-1:0]                      cfg_data,
   output logic [NSEG-1:0][TW-1:0]            seg_start_o,
   output logic [NSEG-1:0][OCW-1:0]           seg_cnt_o,
   output logic [NSEG-1:0][LW-1:0]            seg_len_o,
   output logic [NSEG-1:0][NOWN-1:0][PW-1:0]  own_id_o,
   output logic [NSEG-1:0][NOWN-1:0][LW-1:0]  own_len_o,
   output logic [CSW-1:0]                     nseg_o,
   output logic [TW-1:0]                      period_o
);
   logic wr;
   assign wr = cfg_we && wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSEG; s++) begin
            seg_start_o[s] <= '0;
            seg_cnt_o[s]   <= OCW'(1);
            seg_len_o[s]   <= LW'(1);
            for (int k = 0; k < NOWN; k++) begin
               own_id_o[s][k]  <= '0;
               own_len_o[s][k] <= LW'(1);
            end
         end
         nseg_o   <= CSW'(1);
         period_o <= TW'(1);
      end else if (wr) begin
         case (cfg_field_e'(cfg_field))
            FLD_SEG_START: seg_start_o[cfg_seg]         <= cfg_data;
            FLD_SEG_CNT:   seg_cnt_o[cfg_seg]           <= cfg_data[OCW-1:0];
            FLD_SEG_LEN:   seg_len_o[cfg_seg]           <= cfg_data[LW-1:0];
            FLD_OWN_ID:    own_id_o[cfg_seg][cfg_idx]   <= cfg_data[PW-1:0];
            FLD_OWN_LEN:   own_len_o[cfg_seg][cfg_idx]  <= cfg_data[LW-1:0];
            FLD_NSEG:      nseg_o                       <= cfg_data[CSW-1:0];
            FLD_PERIOD:    period_o                     <= cfg_data;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tdma_slot_seq.sv
module tdma_slot_seq
   import tdma_pkg::*;
#(
   parameter int MODE  = MODE_PER,
   parameter int NPROC = 4,
   parameter int NSEG  = 4,
   parameter int NOWN  = 4,
   parameter int TW    = 16,
   parameter int LW    = 8,
   localparam int PW   = $clog2(NPROC),
   localparam int SW   = $clog2(NSEG),
   localparam int OW   = $clog2(NOWN),
   localparam int CSW  = $clog2(NSEG + 1),
   localparam int OCW  = $clog2(NOWN + 1)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               en,
   input  logic [NSEG-1:0][TW-1:0]            seg_start_i,
   input  logic [NSEG-1:0][OCW-1:0]           seg_cnt_i,
   input  logic [NSEG-1:0][LW-1:0]            seg_len_i,
   input  logic [NSEG-1:0][NOWN-1:0][PW-1:0]  own_id_i,
   input  logic [NSEG-1:0][NOWN-1:0][LW-1:0]  own_len_i,
   input  logic [CSW-1:0]                     nseg_i,
   input  logic [TW-1:0]                      period_i,
   output logic                               started_o,
   output logic                               bnd_o,
   output logic [PW-1:0]                      own_nx_o
);
   logic [TW-1:0] t_q, n_t, t_inc, nxt_start;
   logic [SW-1:0] s_q, n_s;
   logic [OW-1:0] k_q, n_k;
   logic [LW-1:0] r_q, n_r, len_nx;
   logic [CSW-1:0] s_inc;
   logic [OCW-1:0] k_inc;
   logic wrap, seg_hit, k_wrap, slot_end, bnd;

   // Next position in the schedule: period wrap, segment change, slot change.
   always_comb begin
      t_inc     = t_q + 1'b1;
      wrap      = (t_q == period_i - 1'b1);
      s_inc     = CSW'(s_q) + 1'b1;
      nxt_start = (s_inc < nseg_i) ? seg_start_i[SW'(s_inc)] : '0;
      seg_hit   = (s_inc < nseg_i) && (t_inc == nxt_start);
      k_inc     = OCW'(k_q) + 1'b1;
      k_wrap    = (k_inc >= seg_cnt_i[s_q]);
      n_t = t_inc;
      n_s = s_q;
      n_k = k_q;
      bnd = 1'b0;
      if (!started_o || wrap) begin
         n_t = '0;
         n_s = '0;
         n_k = '0;
         bnd = 1'b1;
      end else if (seg_hit) begin
         n_s = SW'(s_inc);
         n_k = '0;
         bnd = 1'b1;
      end else if (slot_end) begin
         n_k = k_wrap ? '0 : OW'(k_inc);
         bnd = 1'b1;
      end
   end

   // Slot-length source chosen by the table mode.
   generate
      if (MODE == MODE_PER) begin : g_per
         logic unused_len;
         assign unused_len = ^seg_len_i;
         assign slot_end   = (r_q == LW'(1));
         assign len_nx     = own_len_i[n_s][n_k];
      end else if (MODE == MODE_UNI) begin : g_uni
         logic unused_len;
         assign unused_len = ^own_len_i;
         assign slot_end   = (r_q == LW'(1));
         assign len_nx     = seg_len_i[n_s];
      end else begin : g_flat
         logic unused_len;
         assign unused_len = ^{own_len_i, seg_len_i};
         assign slot_end   = 1'b0;
         assign len_nx     = '0;
      end
   endgenerate

   assign n_r = bnd ? len_nx : r_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started_o <= 1'b0;
         t_q <= '0;
         s_q <= '0;
         k_q <= '0;
         r_q <= '0;
      end else if (!en) begin
         started_o <= 1'b0;
         t_q <= '0;
         s_q <= '0;
         k_q <= '0;
         r_q <= '0;
      end else begin
         started_o <= 1'b1;
         t_q <= n_t;
         s_q <= n_s;
         k_q <= n_k;
         r_q <= n_r;
      end
   end

   assign bnd_o    = en && bnd;
   assign own_nx_o = own_id_i[n_s][n_k];
endmodule

// File: rtl/tdma_grant_reg.sv
module tdma_grant_reg #(
   parameter int NPROC = 4,
   localparam int PW   = $clog2(NPROC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bnd,
   input  logic [PW-1:0]    own_nx,
   input  logic [NPROC-1:0] req,
   output logic [NPROC-1:0] gnt,
   output logic [PW-1:0]    owner
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt   <= '0;
         owner <= '0;
      end else if (!en) begin
         gnt   <= '0;
         owner <= '0;
      end else if (bnd) begin
         gnt   <= req[own_nx] ? (NPROC'(1) << own_nx) : '0;
         owner <= own_nx;
      end
   end
endmodule

// File: rtl/tdma_seg_arbiter.sv
module tdma_seg_arbiter
   import tdma_pkg::*;
#(
   parameter int MODE  = MODE_PER,
   parameter int NPROC = 4,
   parameter int NSEG  = 4,
   parameter int NOWN  = 4,
   parameter int TW    = 16,
   parameter int LW    = 8,
   localparam int PW   = $clog2(NPROC),
   localparam int SW   = $clog2(NSEG),
   localparam int OW   = $clog2(NOWN),
   localparam int CSW  = $clog2(NSEG + 1),
   localparam int OCW  = $clog2(NOWN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [NPROC-1:0] req,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_field,
   input  logic [SW-1:0]    cfg_seg,
   input  logic [OW-1:0]    cfg_idx,
   input  logic [TW-1:0]    cfg_data,
   output logic [NPROC-1:0] gnt,
   output logic [PW-1:0]    owner
);
   generate
      if (NPROC < 2 || NPROC > 8) begin : g_bad_nproc
         $error("NPROC must lie in 2..8");
      end
      if (NSEG < 2 || NSEG > 8) begin : g_bad_nseg
         $error("NSEG must lie in 2..8");
      end
      if (NOWN < 2 || NOWN > 8) begin : g_bad_nown
         $error("NOWN must lie in 2..8");
      end
      if (LW < 1 || LW > 8) begin : g_bad_lw
         $error("LW must lie in 1..8");
      end
      if (MODE != MODE_FLAT && MODE != MODE_UNI && MODE != MODE_PER) begin : g_bad_mode
         $error("MODE must be flat, uniform or per-owner");
      end
   endgenerate

   logic [NSEG-1:0][TW-1:0]           seg_start;
   logic [NSEG-1:0][OCW-1:0]          seg_cnt;
   logic [NSEG-1:0][LW-1:0]           seg_len;
   logic [NSEG-1:0][NOWN-1:0][PW-1:0] own_id;
   logic [NSEG-1:0][NOWN-1:0][LW-1:0] own_len;
   logic [CSW-1:0]                    nseg;
   logic [TW-1:0]                     period;
   logic                              started, slot_bnd;
   logic [PW-1:0]                     own_nx;

   tdma_sched_table #(
      .NPROC(NPROC), .NSEG(NSEG), .NOWN(NOWN), .TW(TW), .LW(LW)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .wr_ok(!en),
      .cfg_we(cfg_we), .cfg_field(cfg_field), .cfg_seg(cfg_seg),
      .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .seg_start_o(seg_start), .seg_cnt_o(seg_cnt), .seg_len_o(seg_len),
      .own_id_o(own_id), .own_len_o(own_len), .nseg_o(nseg), .period_o(period)
   );

   tdma_slot_seq #(
      .MODE(MODE), .NPROC(NPROC), .NSEG(NSEG), .NOWN(NOWN), .TW(TW), .LW(LW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en),
      .seg_start_i(seg_start), .seg_cnt_i(seg_cnt), .seg_len_i(seg_len),
      .own_id_i(own_id), .own_len_i(own_len), .nseg_i(nseg), .period_i(period),
      .started_o(started), .bnd_o(slot_bnd), .own_nx_o(own_nx)
   );

   tdma_grant_reg #(.NPROC(NPROC)) u_gnt (
      .clk(clk), .rst_n(rst_n), .en(en), .bnd(slot_bnd),
      .own_nx(own_nx), .req(req), .gnt(gnt), .owner(owner)
   );
endmodule

// File: rtl/tdma_seg_arbiter_chk.sv
module tdma_seg_arbiter_chk #(
   parameter int NPROC = 4,
   localparam int PW   = $clog2(NPROC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [NPROC-1:0] req,
   input logic [NPROC-1:0] gnt,
   input logic [PW-1:0]    owner,
   input logic             started,
   input logic             slot_bnd,
   input logic [PW-1:0]    own_nx
);
   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   a_r2_owner_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0) |-> (gnt == (NPROC'(1) << owner)));

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && started && !slot_bnd) |=> ($stable(gnt) && $stable(owner)));

   a_r4_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (gnt == '0 && owner == '0));

   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_bnd && !req[own_nx]) |=> (gnt == '0));

   a_r12_take: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_bnd && req[own_nx]) |=> (gnt != '0));
endmodule

bind tdma_seg_arbiter tdma_seg_arbiter_chk #(.NPROC(NPROC)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .req(req), .gnt(gnt), .owner(owner),
   .started(started), .slot_bnd(slot_bnd), .own_nx(own_nx)
);

// File: tb/tb_tdma_seg_arbiter.sv
module tb_tdma_seg_arbiter;
   import tdma_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [3:0]  req = 4'h0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_field = 3'd0;
   logic [1:0]  cfg_seg = 2'd0;
   logic [1:0]  cfg_idx = 2'd0;
   logic [15:0] cfg_data = 16'd0;
   logic [3:0]  gnt_p, gnt_u, gnt_f;
   logic [1:0]  own_p, own_u, own_f;

   int total = 0;
   int bad = 0;
   bit done = 0;
   int cyc = 0;
   logic [3:0] req_seen = 4'h0;
   logic [3:0] eg[3];

   int m_start[4], m_cnt[4], m_slen[4], m_id[4][4], m_olen[4][4];
   int m_nseg, m_period;

   always #4 clk = ~clk;

   tdma_seg_arbiter #(.MODE(MODE_PER)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .req(req), .cfg_we(cfg_we),
      .cfg_field(cfg_field), .cfg_seg(cfg_seg), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .gnt(gnt_p), .owner(own_p));
   tdma_seg_arbiter #(.MODE(MODE_UNI)) dut_uni (
      .clk(clk), .rst_n(rst_n), .en(en), .req(req), .cfg_we(cfg_we),
      .cfg_field(cfg_field), .cfg_seg(cfg_seg), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .gnt(gnt_u), .owner(own_u));
   tdma_seg_arbiter #(.MODE(MODE_FLAT)) dut_flat (
      .clk(clk), .rst_n(rst_n), .en(en), .req(req), .cfg_we(cfg_we),
      .cfg_field(cfg_field), .cfg_seg(cfg_seg), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .gnt(gnt_f), .owner(own_f));

   task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Schedule model: owner at time t and whether t opens a slot.
   function automatic void model(int mode, int t, output int own, output bit st);
      int s = 0;
      int off, round, o, acc;
      for (int i = 1; i < m_nseg; i++) if (t >= m_start[i]) s = i;
      off = t - m_start[s];
      own = m_id[s][0];
      st  = (off == 0);
      if (mode == MODE_UNI) begin
         own = m_id[s][(off / m_slen[s]) % m_cnt[s]];
         st  = (off % m_slen[s]) == 0;
      end else if (mode == MODE_PER) begin
         round = 0;
         for (int k = 0; k < m_cnt[s]; k++) round += m_olen[s][k];
         o = off % round;
         acc = 0;
         for (int k = 0; k < m_cnt[s]; k++) begin
            if (o >= acc && o < acc + m_olen[s][k]) begin
               own = m_id[s][k];
               st  = (o == acc);
            end
            acc += m_olen[s][k];
         end
      end
   endfunction

   task automatic put(logic [2:0] f, int s, int k, int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_field = f; cfg_seg = 2'(s); cfg_idx = 2'(k); cfg_data = 16'(d);
      @(negedge clk);
      cfg_we = 1'b0;
      case (f)
         3'd0: m_start[s] = d;
         3'd1: m_cnt[s] = d;
         3'd2: m_slen[s] = d;
         3'd3: m_id[s][k] = d;
         3'd4: m_olen[s][k] = d;
         3'd5: m_nseg = d;
         default: m_period = d;
      endcase
   endtask

   task automatic seg(int s, int start, int cnt, int slen);
      put(3'd0, s, 0, start);
      put(3'd1, s, 0, cnt);
      put(3'd2, s, 0, slen);
   endtask

   task automatic own(int s, int k, int id, int len);
      put(3'd3, s, k, id);
      put(3'd4, s, k, len);
   endtask

   task automatic start_run(logic [3:0] r);
      @(negedge clk);
      req = r;
      en = 1'b1;
      req_seen = r;
      cyc = 0;
   endtask

   task automatic stop_run();
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      // R4: disabled arbiter drives no grant
      check("R4", "gnt per", gnt_p, 4'h0);
      check("R4", "gnt uni", gnt_u, 4'h0);
      check("R4", "gnt flat", gnt_f, 4'h0);
      check("R4", "owner per", {2'b0, own_p}, 4'h0);
   endtask

   task automatic cmp_one(string tag, string nm, int mode, logic [3:0] g, logic [1:0] o);
      int mown;
      bit st;
      model(mode, cyc % m_period, mown, st);
      if (st) eg[mode] = req_seen[mown] ? (4'b1 << mown) : 4'h0;
      check(tag, {"gnt ", nm}, g, eg[mode]);
      check(tag, {"owner ", nm}, {2'b0, o}, 4'(mown));
   endtask

   task automatic run(string tag, int n, int flip_at, logic [3:0] flip_val, int wr_at);
      repeat (n) begin
         @(negedge clk);
         cmp_one(tag, "per", MODE_PER, gnt_p, own_p);
         cmp_one(tag, "uni", MODE_UNI, gnt_u, own_u);
         cmp_one(tag, "flat", MODE_FLAT, gnt_f, own_f);
         if (cyc == flip_at) req = flip_val;
         if (cyc == wr_at) begin
            cfg_we = 1'b1; cfg_field = 3'd0; cfg_seg = 2'd1; cfg_data = 16'd10;
         end else begin
            cfg_we = 1'b0;
         end
         req_seen = req;
         cyc++;
      end
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      // R4: reset state
      check("R4", "reset gnt per", gnt_p, 4'h0);
      check("R4", "reset gnt uni", gnt_u, 4'h0);
      check("R4", "reset gnt flat", gnt_f, 4'h0);
      check("R4", "reset owner", {2'b0, own_p}, 4'h0);
   endtask

   task automatic t_program();
      // R13: table loaded through the field codes while disabled
      seg(0, 0, 2, 2);  own(0, 0, 1, 1); own(0, 1, 2, 3);
      seg(1, 24, 3, 3); own(1, 0, 3, 2); own(1, 1, 0, 1); own(1, 2, 2, 4);
      seg(2, 34, 1, 2); own(2, 0, 0, 2);
      put(3'd5, 0, 0, 3);
      put(3'd6, 0, 0, 40);
      check("R4", "gnt while loading", gnt_p | gnt_u | gnt_f, 4'h0);
   endtask

   task automatic t_all_req();
      // R1 R2 R3 R6 R7 R8 R9 R10: every processor requesting, two periods
      start_run(4'hF);
      run("R6/R7/R8/R9/R10", 80, -1, 4'h0, -1);
      stop_run();
   endtask

   task automatic t_idle();
      // R11: only processor 2 requests; other slots stay idle
      start_run(4'b0100);
      run("R11", 40, -1, 4'h0, -1);
      stop_run();
   endtask

   task automatic t_late_req();
      // R12: request rises inside owner 2's slot
      start_run(4'h0);
      run("R12", 40, 1, 4'b0100, -1);
      stop_run();
   endtask

   task automatic t_locked_write();
      // R5: segment 1 start written as 10 while running; model keeps 24
      start_run(4'hF);
      run("R5", 80, -1, 4'h0, 5);
      stop_run();
   endtask

   task automatic t_reprogram();
      // R13: new segment start and period take effect after re-enable
      put(3'd0, 1, 0, 16);
      put(3'd6, 0, 0, 36);
      start_run(4'b1011);
      run("R13", 72, -1, 4'h0, -1);
      stop_run();
   endtask

   initial begin
      for (int i = 0; i < 3; i++) eg[i] = 4'h0;
      for (int s = 0; s < 4; s++) begin
         m_start[s] = 0; m_cnt[s] = 1; m_slen[s] = 1;
         for (int k = 0; k < 4; k++) begin
            m_id[s][k] = 0; m_olen[s][k] = 1;
         end
      end
      m_nseg = 1; m_period = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_all_req();
      t_idle();
      t_late_req();
      t_locked_write();
      t_reprogram();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule